// File: doc/BRIEF.md
# Pixel Capture Crop and Decimate Window

This block sits in a pixel capture path, downstream of the logic that recovers sensor timing. It receives one pixel per valid cycle with a frame-start marker on the first pixel of a frame and a line-start marker on the first pixel of every line. It forwards only the pixels inside a programmable rectangle. The rectangle is given by a column and row offset and a width and height. Either axis can also be halved by dropping every second column or every second line of the rectangle.

Rectangle sizes and the sensor frame size use the minus-one form: each 32-bit size word holds the count minus one, with the horizontal count in bits 15:0 and the vertical count in bits 31:16. The configuration inputs are sampled on the frame-start pixel and held for the rest of that frame. A rectangle that reaches past the sensor frame is clipped to the overlap, and this raises a sticky overflow flag. The output is a registered valid/data stream that flags the first forwarded pixel of the frame and the last forwarded pixel of each kept line.

A three-state controller sequences each frame. `ST_WAIT_SOF` is held from reset until the first frame start; nothing is forwarded in this state. On a frame-start pixel the controller moves to `ST_SCAN` while window pixels remain. It moves straight to `ST_DRAIN` when the clipped window is empty or the frame-start pixel is itself the last window pixel. `ST_SCAN` moves to `ST_DRAIN` on the last kept pixel of the last kept line, and restarts itself on any new frame start. `ST_DRAIN` forwards nothing until the next frame start, which applies the same choice as `ST_WAIT_SOF`.

Top module: `pix_window`

## Requirements
- R1: After reset, `out_valid` is 0 and `overflow` is 0.
- R2: A pixel at column c and line r of the frame is forwarded when left <= c < left+width and top <= r < top+height. Width-1 is taken from `cfg_size[15:0]` and height-1 from `cfg_size[31:16]`. The column is counted from 0 at the line-start pixel, and the line is counted from 0 at the frame-start pixel.
- R3: The sensor frame is (`cfg_sensor[15:0]`+1) columns by (`cfg_sensor[31:16]`+1) lines. Only the part of the window inside the sensor frame is forwarded. Offsets reach up to 8191 columns (13 bits) and 4095 lines (12 bits), so windows deep inside tall frames such as 625 lines are reachable.
- R4: `overflow` goes to 1 on a frame-start pixel whose configuration has left+width greater than the sensor width or top+height greater than the sensor height. It stays 1 until reset, and in-bounds windows leave it at 0.
- R5: With `cfg_hdown` = 1, only window columns left, left+2, left+4, … are forwarded.
- R6: With `cfg_vdown` = 1, only window lines top, top+2, top+4, … are forwarded.
- R7: Horizontal and vertical halving work together when both are enabled.
- R8: `out_sof` is 1 on the first forwarded pixel of each frame and on no other pixel.
- R9: `out_eol` is 1 on the last forwarded pixel of every kept line and on no other pixel.
- R10: Configuration changes take effect only at the next frame-start pixel, and that frame-start pixel already uses the new values. Changes during a frame do not alter that frame.
- R11: A forwarded pixel appears on `out_data` unchanged, one clock after the cycle in which it was presented. No output is valid in the cycle after an input cycle without `in_valid`.
- R12: Valid pixels that arrive before the first frame start after reset are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame (with in_valid) |
| in_sol | input | 1 | First pixel of a line (with in_valid) |
| in_data | input | DATA_W | Input pixel value |
| cfg_left | input | LEFT_W | First window column |
| cfg_top | input | TOP_W | First window line |
| cfg_size | input | 32 | Window height-1 (31:16), width-1 (15:0) |
| cfg_sensor | input | 32 | Sensor height-1 (31:16), width-1 (15:0) |
| cfg_hdown | input | 1 | Keep every second window column |
| cfg_vdown | input | 1 | Keep every second window line |
| out_valid | output | 1 | Output pixel present |
| out_data | output | DATA_W | Output pixel value |
| out_sof | output | 1 | First forwarded pixel of the frame |
| out_eol | output | 1 | Last forwarded pixel of the line |
| overflow | output | 1 | Sticky: a window exceeded the sensor frame |

## Verification
The assertions assume that `in_sof` and `in_sol` are raised only together with `in_valid`. They also assume that every frame-start pixel is at column 0 of line 0, and that a line-start pixel opens every line. The stimulus builds each frame as whole lines, with both markers on the opening pixel and idle gaps only between lines. It changes the configuration both on the frame-start cycle and partway through a frame, so that both ways of updating are covered. Pixel values encode line and column, so any misplaced, dropped or duplicated pixel shows up in the value comparison.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    localparam int SIZE_W = 16;
    localparam int POS_W  = SIZE_W + 1;

    typedef enum logic [1:0] {
        ST_WAIT_SOF = 2'd0,
        ST_SCAN     = 2'd1,
        ST_DRAIN    = 2'd2
    } pcw_state_e;

    typedef struct packed {
        logic [POS_W-1:0] first;
        logic [POS_W-1:0] last;
        logic             down;
        logic             empty;
        logic             over;
    } pcw_axis_t;
endpackage

// File: rtl/pcw_axis.sv
module pcw_axis
    import pcw_pkg::*;
#(
    parameter int START_W = 13
) (
    input  logic [START_W-1:0] start,
    input  logic [SIZE_W-1:0]  len_m1,
    input  logic [SIZE_W-1:0]  sens_m1,
    input  logic               down,
    output pcw_axis_t          ax
);
    logic [POS_W-1:0] start_x;
    logic [POS_W-1:0] len_x;
    logic [POS_W-1:0] sens_x;
    logic [POS_W-1:0] stop_x;
    logic [POS_W-1:0] end_x;
    logic [POS_W-1:0] span_x;

    always_comb begin
        start_x  = POS_W'(start);
        len_x    = {1'b0, len_m1} + POS_W'(1);
        sens_x   = {1'b0, sens_m1} + POS_W'(1);
        stop_x   = start_x + len_x;
        end_x    = (stop_x > sens_x) ? sens_x : stop_x;
        span_x   = end_x - POS_W'(1) - start_x;
        ax.first = start_x;
        ax.last  = down ? (start_x + {span_x[POS_W-1:1], 1'b0})
                        : (end_x - POS_W'(1));
        ax.down  = down;
        ax.empty = (start_x >= sens_x);
        ax.over  = (stop_x > sens_x);
    end
endmodule

// File: rtl/pcw_position.sv
module pcw_position
    import pcw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_sol,
    output logic [POS_W-1:0] cur_col,
    output logic [POS_W-1:0] cur_row
);
    logic [POS_W-1:0] col_q;
    logic [POS_W-1:0] row_q;

    always_comb begin
        cur_col = (in_sof || in_sol) ? '0 : col_q + POS_W'(1);
        if (in_sof)
            cur_row = '0;
        else if (in_sol)
            cur_row = row_q + POS_W'(1);
        else
            cur_row = row_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (in_valid) begin
            col_q <= cur_col;
            row_q <= cur_row;
        end
    end
endmodule

// File: rtl/pcw_ctrl.sv
module pcw_ctrl
    import pcw_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    input  logic [POS_W-1:0]  cur_col,
    input  logic [POS_W-1:0]  cur_row,
    input  pcw_axis_t         ax_h_new,
    input  pcw_axis_t         ax_v_new,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eol,
    output logic              overflow
);
    pcw_state_e state_q, state_d;
    pcw_axis_t  win_h_q, win_v_q;
    pcw_axis_t  win_h, win_v;
    logic       first_pend_q;
    logic       start_pix;
    logic       allowed;
    logic       hit_h, hit_v;
    logic       keep;
    logic       line_end;
    logic       frame_end;
    pcw_state_e enter_state;

    function automatic logic axis_hit(input logic [POS_W-1:0] pos,
                                      input pcw_axis_t a);
        logic [POS_W-1:0] rel;
        rel = pos - a.first;
        return !a.empty && (pos >= a.first) && (pos <= a.last) &&
               (!a.down || !rel[0]);
    endfunction

    always_comb begin
        start_pix = in_valid && in_sof;
        win_h     = start_pix ? ax_h_new : win_h_q;
        win_v     = start_pix ? ax_v_new : win_v_q;
        allowed   = start_pix || (state_q == ST_SCAN);
        hit_h     = axis_hit(cur_col, win_h);
        hit_v     = axis_hit(cur_row, win_v);
        keep      = in_valid && allowed && hit_h && hit_v;
        line_end  = keep && (cur_col == win_h.last);
        frame_end = line_end && (cur_row == win_v.last);
        enter_state = (frame_end || win_h.empty || win_v.empty) ? ST_DRAIN : ST_SCAN;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SOF: if (start_pix) state_d = enter_state;
            ST_SCAN: begin
                if (start_pix)      state_d = enter_state;
                else if (frame_end) state_d = ST_DRAIN;
            end
            ST_DRAIN:    if (start_pix) state_d = enter_state;
            default:     state_d = ST_WAIT_SOF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_SOF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_h_q       <= '{first: '0, last: '0, down: 1'b0, empty: 1'b1, over: 1'b0};
            win_v_q       <= '{first: '0, last: '0, down: 1'b0, empty: 1'b1, over: 1'b0};
            first_pend_q  <= 1'b0;
            overflow      <= 1'b0;
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_sof       <= 1'b0;
            out_eol       <= 1'b0;
        end else begin
            if (start_pix) begin
                win_h_q <= ax_h_new;
                win_v_q <= ax_v_new;
                if (ax_h_new.over || ax_v_new.over) overflow <= 1'b1;
            end
            if (keep)           first_pend_q <= 1'b0;
            else if (start_pix) first_pend_q <= 1'b1;
            out_valid <= keep;
            out_sof   <= keep && (start_pix || first_pend_q);
            out_eol   <= line_end;
            if (keep) out_data <= in_data;
        end
    end

    a_r11_no_input_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !out_valid);

    a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow) |-> overflow);

    a_r10_window_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pix |=> ($stable(win_h_q) && $stable(win_v_q)));

    a_r12_drain_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SCAN && !start_pix) |=> !out_valid);
endmodule

// File: rtl/pix_window.sv
module pix_window
    import pcw_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LEFT_W = 13,
    parameter int TOP_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic                in_sol,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [LEFT_W-1:0]   cfg_left,
    input  logic [TOP_W-1:0]    cfg_top,
    input  logic [2*SIZE_W-1:0] cfg_size,
    input  logic [2*SIZE_W-1:0] cfg_sensor,
    input  logic                cfg_hdown,
    input  logic                cfg_vdown,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_sof,
    output logic                out_eol,
    output logic                overflow
);
    pcw_axis_t        ax_h, ax_v;
    logic [POS_W-1:0] cur_col, cur_row;

    pcw_axis #(.START_W(LEFT_W)) u_axis_h (
        .start   (cfg_left),
        .len_m1  (cfg_size[SIZE_W-1:0]),
        .sens_m1 (cfg_sensor[SIZE_W-1:0]),
        .down    (cfg_hdown),
        .ax      (ax_h)
    );

    pcw_axis #(.START_W(TOP_W)) u_axis_v (
        .start   (cfg_top),
        .len_m1  (cfg_size[2*SIZE_W-1:SIZE_W]),
        .sens_m1 (cfg_sensor[2*SIZE_W-1:SIZE_W]),
        .down    (cfg_vdown),
        .ax      (ax_v)
    );

    pcw_position u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_sol   (in_sol),
        .cur_col  (cur_col),
        .cur_row  (cur_row)
    );

    pcw_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .cur_col   (cur_col),
        .cur_row   (cur_row),
        .ax_h_new  (ax_h),
        .ax_v_new  (ax_v),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eol   (out_eol),
        .overflow  (overflow)
    );
endmodule

// File: tb/pix_window_bench.sv
module pix_window_bench;
    localparam int DATA_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic              in_sol = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [12:0]       cfg_left = '0;
    logic [11:0]       cfg_top = '0;
    logic [31:0]       cfg_size = '0;
    logic [31:0]       cfg_sensor = '0;
    logic              cfg_hdown = 1'b0;
    logic              cfg_vdown = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_sof;
    logic              out_eol;
    logic              overflow;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int sof_cyc = 0;
    bit exp_ovf = 1'b0;
    bit done = 1'b0;

    logic [DATA_W-1:0] got_d[$];
    bit                got_s[$];
    bit                got_e[$];
    int                got_c[$];

    always #2 clk = ~clk;

    pix_window u_pix_window (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_data(in_data), .cfg_left(cfg_left), .cfg_top(cfg_top),
        .cfg_size(cfg_size), .cfg_sensor(cfg_sensor), .cfg_hdown(cfg_hdown),
        .cfg_vdown(cfg_vdown), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eol(out_eol), .overflow(overflow)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_d.push_back(out_data);
            got_s.push_back(out_sof);
            got_e.push_back(out_eol);
            got_c.push_back(cyc);
        end
    end

    task automatic check(string tag, bit ok, int act, int exp, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit in_axis(int p, int s, int n, int lim, bit dn);
        return (p >= s) && (p < s + n) && (p < lim) && (!dn || ((p - s) % 2 == 0));
    endfunction

    task automatic put_cfg(int sw, int sh, int l, int t, int w, int h, bit hd, bit vd);
        cfg_left   = 13'(l);
        cfg_top    = 12'(t);
        cfg_size   = {16'(h - 1), 16'(w - 1)};
        cfg_sensor = {16'(sh - 1), 16'(sw - 1)};
        cfg_hdown  = hd;
        cfg_vdown  = vd;
    endtask

    // Drive one frame, compare forwarded pixels, sof and eol flags with the model.
    task automatic run_frame(string tag, int sw, int sh, int l, int t, int w, int h,
                             bit hd, bit vd, int chg_row);
        logic [DATA_W-1:0] ed[$];
        bit es[$];
        bit ee[$];
        int bad = 0;
        got_d.delete(); got_s.delete(); got_e.delete(); got_c.delete();
        for (int r = 0; r < sh; r++) begin
            int lastc = -1;
            if (!in_axis(r, t, h, sh, vd)) continue;
            for (int c = 0; c < sw; c++) if (in_axis(c, l, w, sw, hd)) lastc = c;
            for (int c = 0; c < sw; c++) begin
                if (in_axis(c, l, w, sw, hd)) begin
                    ed.push_back({r[4:0], c[4:0]});
                    es.push_back(ed.size() == 1);
                    ee.push_back(c == lastc);
                end
            end
        end
        if ((l + w > sw) || (t + h > sh)) exp_ovf = 1'b1;
        for (int r = 0; r < sh; r++) begin
            for (int c = 0; c < sw; c++) begin
                @(negedge clk);
                if (r == 0 && c == 0) begin
                    put_cfg(sw, sh, l, t, w, h, hd, vd);
                    sof_cyc = cyc;
                end
                if (r == chg_row && c == 0) put_cfg(sw, sh, 0, 0, sw, sh, !hd, !vd);
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_sol   = (c == 0);
                in_data  = {r[4:0], c[4:0]};
            end
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(tag, got_d.size() == ed.size(), got_d.size(), ed.size(), "forwarded count");
        for (int i = 0; i < ed.size() && i < got_d.size(); i++)
            if (got_d[i] != ed[i]) bad++;
        check(tag, bad == 0, bad, 0, "pixel value mismatches");
        bad = 0;
        for (int i = 0; i < es.size() && i < got_s.size(); i++)
            if (got_s[i] != es[i]) bad++;
        check("R8", bad == 0, bad, 0, "sof flag mismatches");
        bad = 0;
        for (int i = 0; i < ee.size() && i < got_e.size(); i++)
            if (got_e[i] != ee[i]) bad++;
        check("R9", bad == 0, bad, 0, "eol flag mismatches");
        check("R4", overflow == exp_ovf, overflow, exp_ovf, "overflow flag");
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", out_valid == 1'b0, out_valid, 0, "out_valid after reset");
        check("R1", overflow == 1'b0, overflow, 0, "overflow after reset");
    endtask

    task automatic test_before_first_frame();
        got_d.delete();
        put_cfg(12, 8, 0, 0, 12, 8, 1'b0, 1'b0);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_sol = (c == 0); in_data = DATA_W'(c);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
        repeat (2) @(negedge clk);
        check("R12", got_d.size() == 0, got_d.size(), 0, "pixels before frame start");
    endtask

    task automatic test_full_frame();
        run_frame("R2", 12, 8, 0, 0, 12, 8, 1'b0, 1'b0, -1);
        check("R11", got_c.size() > 0 && got_c[0] == sof_cyc + 1,
              got_c.size() > 0 ? got_c[0] - sof_cyc : -1, 1, "latency in cycles");
    endtask

    task automatic test_crop();      run_frame("R2", 12, 8, 3, 2, 5, 4, 1'b0, 1'b0, -1); endtask
    task automatic test_hdown();     run_frame("R5", 12, 8, 2, 1, 7, 3, 1'b1, 1'b0, -1); endtask
    task automatic test_vdown();     run_frame("R6", 12, 8, 1, 1, 4, 5, 1'b0, 1'b1, -1); endtask
    task automatic test_both();      run_frame("R7", 12, 8, 0, 0, 12, 8, 1'b1, 1'b1, -1); endtask
    task automatic test_clip();      run_frame("R3", 12, 8, 9, 6, 8, 5, 1'b0, 1'b0, -1); endtask
    task automatic test_mid_change(); run_frame("R10", 12, 8, 2, 2, 6, 4, 1'b0, 1'b0, 3); endtask
    task automatic test_tall_frame(); run_frame("R3", 4, 625, 1, 620, 2, 5, 1'b0, 1'b0, -1); endtask

    initial begin
        test_reset();
        test_before_first_frame();
        test_full_frame();
        test_crop();
        test_hdown();
        test_vdown();
        test_both();
        test_clip();
        test_mid_change();
        test_tall_frame();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule